// File: doc/BRIEF.md
# Random Generator Register Interface

This block is the register front end of a hardware random number generator. Software reaches it over a simple 32-bit bus with an address, a write enable, write data, a read strobe and combinational read data. A control register gates generation and the interrupt. A status register reports data ready, the live clock-error and seed-error conditions, and two sticky interrupt flags that latch those conditions. A data register returns the last word captured from the entropy source.

The entropy source delivers 32-bit words through a valid/word port. It also drives two condition inputs: a clock-error level and a seed-error level. A captured word raises data ready. Reading the data register consumes it. Either error condition rising sets its sticky flag. The interrupt output is a level that stays high while an enabled cause is pending. A seed error halts capture. Software recovers by clearing the generation enable and then setting it again.

Top module: `rng_csr_top`

## Requirements
- R1: After reset, the registers at byte offsets 0x0, 0x4 and 0x8 all read 0 and `irq` is low.
- R2: Control (offset 0x0): bit 2 is the generation enable and bit 3 is the interrupt enable. Both are writable and read back. All other control bits read 0 whatever is written.
- R3: With generation enabled and not halted, a cycle with `src_valid` high captures `src_word`. From the next cycle, status bit 0 (ready) reads 1 and offset 0x8 returns the captured word.
- R4: A read strobe at offset 0x8 returns the word and clears ready on the following clock. The word stays readable afterwards. A capture in the same cycle as that read wins, so ready stays 1 and the new word is held.
- R5: While generation is disabled, source words are ignored: the held word and ready do not change. Ready reads 0 from the second clock after the control write that clears the enable.
- R6: Status bit 1 shows `src_clk_err` and bit 2 shows `src_seed_err` in the same cycle. Writes to the status register do not change them.
- R7: A 0-to-1 change on `src_clk_err` sets sticky status bit 5, and a 0-to-1 change on `src_seed_err` sets sticky bit 6. Each sticky bit stays set after its input falls.
- R8: A status write with bit 5 (or 6) at 0 clears that sticky bit. A write with the bit at 1 leaves it unchanged. A rise arriving in the same cycle as a clearing write leaves the bit set.
- R9: `irq` is high exactly when interrupt enable is 1 and at least one of ready, sticky bit 5 or sticky bit 6 is set.
- R10: A rise of `src_seed_err` halts capture. Source words are ignored until generation enable has been 0 for at least one clock and is then set again.
- R11: Offset 0xC reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_re | input | 1 | Read strobe; consumes data at 0x8 |
| bus_rdata | output | BUS_W (32) | Read data for `bus_addr`, combinational |
| src_valid | input | 1 | Source word valid |
| src_word | input | BUS_W (32) | Source random word |
| src_clk_err | input | 1 | Source clock-error condition |
| src_seed_err | input | 1 | Source seed-error condition |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit bus and a 4-bit byte address. These values put all four word offsets within reach, including the unmapped 0xC. Source words with the top bit set check that the full width is captured. The directed scenarios line up stimulus on the same clock edge to cover three races: capture against a consuming read, a sticky rise against a clearing write, and a seed halt against the enable toggle.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 4;
  localparam int OFF_DATA = 8;

  localparam int CTRL_GEN_BIT = 2;
  localparam int CTRL_IE_BIT  = 3;

  localparam int ST_RDY_BIT    = 0;
  localparam int ST_CE_LIVE    = 1;
  localparam int ST_SE_LIVE    = 2;
  localparam int ST_CE_STICKY  = 5;
  localparam int ST_SE_STICKY  = 6;
  localparam int ST_FIELD_W    = 7;

  localparam int N_ERR    = 2;
  localparam int ERR_CLK  = 0;
  localparam int ERR_SEED = 1;

  function automatic logic sticky_next(input logic cur, input logic rise,
                                       input logic clr);
    return rise | (cur & ~clr);
  endfunction

  function automatic logic irq_level(input logic ie, input logic rdy,
                                     input logic [N_ERR-1:0] sticky);
    return ie & (rdy | (|sticky));
  endfunction

  function automatic logic [ST_FIELD_W-1:0] pack_status(
      input logic rdy, input logic [N_ERR-1:0] live,
      input logic [N_ERR-1:0] sticky);
    logic [ST_FIELD_W-1:0] s;
    s = '0;
    s[ST_RDY_BIT]   = rdy;
    s[ST_CE_LIVE]   = live[ERR_CLK];
    s[ST_SE_LIVE]   = live[ERR_SEED];
    s[ST_CE_STICKY] = sticky[ERR_CLK];
    s[ST_SE_STICKY] = sticky[ERR_SEED];
    return s;
  endfunction
endpackage

// File: rtl/rng_ctrl_bank.sv
module rng_ctrl_bank #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic             gen_en,
  output logic             irq_en
);
  import rng_csr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr_en) begin
      gen_en <= wdata[CTRL_GEN_BIT];
      irq_en <= wdata[CTRL_IE_BIT];
    end
  end
endmodule

// File: rtl/rng_err_track.sv
module rng_err_track #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live,
  input  logic [N-1:0] clr,
  output logic [N-1:0] rise,
  output logic [N-1:0] sticky
);
  import rng_csr_pkg::*;

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    assign rise[g] = live[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        sticky[g] <= 1'b0;
      end else begin
        prev_q[g] <= live[g];
        sticky[g] <= sticky_next(sticky[g], rise[g], clr[g]);
      end
    end
  end
endmodule

// File: rtl/rng_data_path.sv
module rng_data_path #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             src_valid,
  input  logic [BUS_W-1:0] src_word,
  input  logic             rd_pop,
  input  logic             seed_rise,
  output logic [BUS_W-1:0] data_q,
  output logic             rdy,
  output logic             halted,
  output logic             cap_evt
);
  assign cap_evt = src_valid & gen_en & ~halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy    <= 1'b0;
      halted <= 1'b0;
    end else begin
      if (cap_evt) data_q <= src_word;

      if (!gen_en)      rdy <= 1'b0;
      else if (cap_evt) rdy <= 1'b1;
      else if (rd_pop)  rdy <= 1'b0;

      if (seed_rise)    halted <= 1'b1;
      else if (!gen_en) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_csr_top.sv
module rng_csr_top #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              src_valid,
  input  logic [BUS_W-1:0]  src_word,
  input  logic              src_clk_err,
  input  logic              src_seed_err,
  output logic              irq
);
  import rng_csr_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

  logic             sel_ctrl, sel_stat, sel_data;
  logic             wr_ctrl, wr_stat, rd_pop;
  logic             gen_en, irq_en;
  logic [N_ERR-1:0] err_live, err_clr, err_rise, err_sticky;
  logic [BUS_W-1:0] data_q;
  logic             rdy, halted, cap_evt;
  logic [BUS_W-1:0] ctrl_word, stat_word;

  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_stat = (bus_addr == A_STAT);
  assign sel_data = (bus_addr == A_DATA);
  assign wr_ctrl  = bus_we & sel_ctrl;
  assign wr_stat  = bus_we & sel_stat;
  assign rd_pop   = bus_re & sel_data;

  assign err_live[ERR_CLK]  = src_clk_err;
  assign err_live[ERR_SEED] = src_seed_err;
  assign err_clr[ERR_CLK]   = wr_stat & ~bus_wdata[ST_CE_STICKY];
  assign err_clr[ERR_SEED]  = wr_stat & ~bus_wdata[ST_SE_STICKY];

  rng_ctrl_bank #(.BUS_W(BUS_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .gen_en (gen_en),
    .irq_en (irq_en)
  );

  rng_err_track #(.N(N_ERR)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (err_live),
    .clr    (err_clr),
    .rise   (err_rise),
    .sticky (err_sticky)
  );

  rng_data_path #(.BUS_W(BUS_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .src_valid (src_valid),
    .src_word  (src_word),
    .rd_pop    (rd_pop),
    .seed_rise (err_rise[ERR_SEED]),
    .data_q    (data_q),
    .rdy       (rdy),
    .halted    (halted),
    .cap_evt   (cap_evt)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_GEN_BIT] = gen_en;
    ctrl_word[CTRL_IE_BIT]  = irq_en;
    stat_word = BUS_W'(pack_status(rdy, err_live, err_sticky));
  end

  always_comb begin
    if (sel_ctrl)      bus_rdata = ctrl_word;
    else if (sel_stat) bus_rdata = stat_word;
    else if (sel_data) bus_rdata = data_q;
    else               bus_rdata = '0;
  end

  assign irq = irq_level(irq_en, rdy, err_sticky);
endmodule

// File: rtl/rng_csr_chk.sv
module rng_csr_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             irq_en,
  input logic             src_valid,
  input logic [BUS_W-1:0] src_word,
  input logic             cap_evt,
  input logic             rdy,
  input logic [BUS_W-1:0] data_q,
  input logic             halted,
  input logic [1:0]       err_rise,
  input logic [1:0]       err_sticky,
  input logic [1:0]       err_clr,
  input logic             irq
);
  // R3
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rdy && data_q == $past(src_word)));
  // R5
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !rdy);
  // R5
  disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && src_valid) |=> $stable(data_q));
  // R7
  clk_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise[0] |=> err_sticky[0]);
  // R7
  seed_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise[1] |=> err_sticky[1]);
  // R8
  sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky[0] && !err_clr[0]) |=> err_sticky[0]);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdy || err_sticky != 2'b00));
  // R10
  halt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && src_valid) |=> $stable(data_q));
endmodule

bind rng_csr_top rng_csr_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .irq_en     (irq_en),
  .src_valid  (src_valid),
  .src_word   (src_word),
  .cap_evt    (cap_evt),
  .rdy        (rdy),
  .data_q     (data_q),
  .halted     (halted),
  .err_rise   (err_rise),
  .err_sticky (err_sticky),
  .err_clr    (err_clr),
  .irq        (irq)
);

// File: tb/rng_csr_top_bench.sv
module rng_csr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        src_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic        src_clk_err = 1'b0;
  logic        src_seed_err = 1'b0;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] held;

  always #4 clk = ~clk;

  rng_csr_top u_rng_csr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .src_valid(src_valid), .src_word(src_word), .src_clk_err(src_clk_err),
    .src_seed_err(src_seed_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    bus_addr = 4'h8; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    src_word = w; src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(4'h0, d); chk("R1 ctrl", d, 32'h0);
    peek(4'h4, d); chk("R1 status", d, 32'h0);
    peek(4'h8, d); chk("R1 data", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF);
    peek(4'h0, d); chk("R2 ctrl readback", d, 32'h0000_000C);
    chk("R2 irq idle", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'h0000_0004);
    peek(4'h0, d); chk("R2 gen only", d, 32'h0000_0004);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    push(32'hA5A5_0001);
    peek(4'h4, d); chk("R3 ready", d, 32'h1);
    peek(4'h8, d); chk("R3 data", d, 32'hA5A5_0001);
    push(32'h8000_00FE);
    peek(4'h8, d); chk("R3 second word", d, 32'h8000_00FE);
  endtask

  task automatic t_pop();
    logic [31:0] d;
    pop(d); chk("R4 pop value", d, 32'h8000_00FE);
    peek(4'h4, d); chk("R4 ready cleared", d, 32'h0);
    peek(4'h8, d); chk("R4 word kept", d, 32'h8000_00FE);
    bus_addr = 4'h8; bus_re = 1'b1; src_word = 32'h1234_5678; src_valid = 1'b1;
    @(negedge clk);
    bus_re = 1'b0; src_valid = 1'b0;
    peek(4'h4, d); chk("R4 capture wins", d, 32'h1);
    peek(4'h8, d); chk("R4 new word", d, 32'h1234_5678);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(4'h0, 32'h0);
    idle();
    peek(4'h4, d); chk("R5 ready cleared on disable", d, 32'h0);
    push(32'hDEAD_BEEF);
    peek(4'h4, d); chk("R5 ignored ready", d, 32'h0);
    peek(4'h8, d); chk("R5 ignored data", d, 32'h1234_5678);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    wr(4'h4, 32'h0000_0066);
    peek(4'h4, d); chk("R6 write ignored", d, 32'h0);
    src_clk_err = 1'b1;
    peek(4'h4, d); chk("R6 live same cycle", d, 32'h0000_0002);
    idle();
    peek(4'h4, d); chk("R7 sticky set", d, 32'h0000_0022);
    src_clk_err = 1'b0;
    idle();
    peek(4'h4, d); chk("R7 sticky kept", d, 32'h0000_0020);
    wr(4'h4, 32'h0000_0060);
    peek(4'h4, d); chk("R8 write one keeps", d, 32'h0000_0020);
    wr(4'h4, 32'h0);
    peek(4'h4, d); chk("R8 write zero clears", d, 32'h0);
    src_clk_err = 1'b1;
    wr(4'h4, 32'h0);
    peek(4'h4, d); chk("R8 rise beats clear", d, 32'h0000_0022);
    src_clk_err = 1'b0;
    idle();
    wr(4'h4, 32'h0);
    peek(4'h4, d); chk("R8 final clear", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(4'h0, 32'h8);
    chk("R9 nothing pending", {31'b0, irq}, 32'h0);
    src_clk_err = 1'b1; idle(); src_clk_err = 1'b0; idle();
    chk("R9 sticky raises", {31'b0, irq}, 32'h1);
    wr(4'h4, 32'h0);
    chk("R9 cleared drops", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'hC);
    push(32'h0BAD_F00D);
    chk("R9 ready raises", {31'b0, irq}, 32'h1);
    pop(d);
    chk("R9 pop drops", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'h4);
    push(32'h0000_0777);
    chk("R9 masked", {31'b0, irq}, 32'h0);
    pop(d);
  endtask

  task automatic t_seed();
    logic [31:0] d;
    held = 32'h0000_0777;
    src_seed_err = 1'b1; idle(); src_seed_err = 1'b0;
    push(32'h5555_AAAA);
    peek(4'h4, d); chk("R10 halted status", d, 32'h0000_0040);
    peek(4'h8, d); chk("R10 halted data", d, held);
    wr(4'h0, 32'h0);
    idle();
    wr(4'h0, 32'h4);
    push(32'hCAFE_0042);
    peek(4'h4, d); chk("R10 resumed status", d, 32'h0000_0041);
    peek(4'h8, d); chk("R10 resumed data", d, 32'hCAFE_0042);
    wr(4'h4, 32'h0);
    peek(4'h4, d); chk("R10 seed sticky cleared", d, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    peek(4'hC, d); chk("R11 unmapped read", d, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);
    peek(4'h0, d); chk("R11 ctrl untouched", d, 32'h4);
    peek(4'h4, d); chk("R11 status untouched", d, 32'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_capture();
    t_pop();
    t_disabled();
    t_errors();
    t_irq();
    t_seed();
    t_unmapped();
    finish_run();
  end
endmodule